// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block sits in the read-data path of an emulated flash device. While an embedded program or erase operation is running, it replaces the array's read data with a status byte. An external timer raises a busy flag and tells the block whether the operation is a program or an erase. For a program, the block also gets the byte that was loaded. Software polls the device by reading it. Two completion signals are presented at the same time:

- The top bit holds the inverse of the final (post-operation) value of that bit.
- The next bit flips on every new read while the operation is running.

When the busy flag drops, true array data is returned on all bits again.

A three-state machine drives the block:

- `ST_IDLE` is pass-through.
- `ST_PROG_BUSY` is entered on a busy edge with the erase flag low. The loaded byte's top bit is captured on that edge.
- `ST_ERASE_BUSY` is entered on a busy edge with the erase flag high.

The transitions are:

- **start_prog**: IDLE to PROG_BUSY.
- **start_erase**: IDLE to ERASE_BUSY.
- **hold**: a busy state stays where it is while busy remains high.
- **finish**: either busy state returns to IDLE on an edge where busy is low.

A separate toggle register holds the flipping bit. It changes only on read-strobe rising edges seen in a busy state.

Top module: `poll_status_mux`

## Requirements
- R1: While `rst_n` is low, the state is IDLE, the toggle register is 0 and the read strobe history is 0. `rd_data_o` equals `array_data_i` (asynchronous reset).
- R2: In IDLE, `rd_data_o` equals `array_data_i` on all bits. IDLE holds in any cycle whose preceding clock edge saw `busy_i` low.
- R3: Leaving IDLE:
  - An edge with `busy_i`=1 and `op_erase_i`=0 takes start_prog.
  - An edge with `busy_i`=1 and `op_erase_i`=1 takes start_erase.
  - Status replaces array data only after that edge; before it, array data still passes.
- R4: In PROG_BUSY, bit 7 equals the inverse of `load_byte_i[7]` as sampled on the start_prog edge.
- R5: In ERASE_BUSY, bit 7 is 0, which is the inverse of the erased value 1.
- R6: In either busy state, bit 6 shows the toggle register. The register inverts on each clock edge taken in a busy state where `rd_strobe_i` is 1 and was 0 at the previous edge.
- R7: The toggle register keeps its value in IDLE. This includes a strobe rise on the same edge that takes start_prog or start_erase, and strobe activity while idle.
- R8: In either busy state, bits 5 to 0 are 0.
- R9: In a busy state, changes of `op_erase_i` and `load_byte_i` have no effect on the state or on bit 7. Changes of `array_data_i` have no effect on any output bit.
- R10: The first edge with `busy_i` low takes finish. From then on all bits carry array data. The toggle value is held into the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Program or erase in progress |
| op_erase_i | input | 1 | 1 = erase, 0 = program, sampled when leaving IDLE |
| load_byte_i | input | DATA_W | Byte loaded for programming |
| rd_strobe_i | input | 1 | Read strobe, one read per rising level change |
| array_data_i | input | DATA_W | Data read from the array |
| rd_data_o | output | DATA_W | Read data returned to the bus |

## Verification
The assertions assume the following about the inputs:

- All inputs are synchronous to `clk`.
- `busy_i` is meaningful only out of reset.
- A read is a strobe level that rises between edges, so the history register sees each rise once.
- No property assumes that `busy_i` stays high for any minimum time.

The stimulus changes every input half a period away from the capturing edge. Strobe rises are spaced by at least one low edge so that each intended read is counted. The stimulus also includes some deliberate violations of good practice: strobe rising on the entry edge, op and load bytes changing mid-operation, and reset asserted in the middle of an operation. These confirm the specified outcome.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PROG_BUSY  = 2'd1,
        ST_ERASE_BUSY = 2'd2
    } poll_state_e;

endpackage

// File: rtl/poll_fsm.sv
module poll_fsm
    import poll_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy_i,
    input  logic        erase_i,
    input  logic        load_msb_i,
    output poll_state_e state_o,
    output logic        inv_msb_o
);

    poll_state_e state_q;
    poll_state_e state_d;
    logic        inv_msb_q;
    logic        inv_msb_d;

    // next-state and capture decision
    always_comb begin
        state_d   = state_q;
        inv_msb_d = inv_msb_q;
        unique case (state_q)
            ST_IDLE: begin
                if (busy_i && !erase_i) begin
                    state_d   = ST_PROG_BUSY;      // start_prog
                    inv_msb_d = ~load_msb_i;
                end else if (busy_i && erase_i) begin
                    state_d   = ST_ERASE_BUSY;     // start_erase
                end
            end
            ST_PROG_BUSY: begin
                if (!busy_i) state_d = ST_IDLE;     // finish
            end
            ST_ERASE_BUSY: begin
                if (!busy_i) state_d = ST_IDLE;     // finish
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            inv_msb_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            inv_msb_q <= inv_msb_d;
        end
    end

    assign state_o   = state_q;
    assign inv_msb_o = inv_msb_q;

    // R10
    finish_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> state_q == ST_IDLE);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) && busy_i |=> (state_q == $past(state_q)) && $stable(inv_msb_q));

    // R3
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && busy_i |=> state_q != ST_IDLE);

endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic strobe_i,
    output logic toggle_o
);

    logic strobe_q;
    logic toggle_q;
    logic read_edge;

    assign read_edge = strobe_i & ~strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            toggle_q <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
            if (active_i && read_edge) begin
                toggle_q <= ~toggle_q;
            end
        end
    end

    assign toggle_o = toggle_q;

    // R7
    idle_toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> $stable(toggle_q));

    // R6
    no_read_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(toggle_q));

endmodule

// File: rtl/poll_mux.sv
module poll_mux
    import poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  poll_state_e        state_i,
    input  logic               inv_msb_i,
    input  logic               toggle_i,
    input  logic [DATA_W-1:0]  array_i,
    output logic [DATA_W-1:0]  data_o
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    // output selection per state
    always_comb begin
        data_o = '0;
        unique case (state_i)
            ST_IDLE: begin
                data_o = array_i;
            end
            ST_PROG_BUSY: begin
                data_o[POLL_BIT] = inv_msb_i;
                data_o[TOG_BIT]  = toggle_i;
            end
            ST_ERASE_BUSY: begin
                data_o[POLL_BIT] = 1'b0;
                data_o[TOG_BIT]  = toggle_i;
            end
            default: data_o = array_i;
        endcase
    end

endmodule

// File: rtl/poll_status_mux.sv
module poll_status_mux
    import poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] load_byte_i,
    input  logic              rd_strobe_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    poll_state_e state_w;
    logic        inv_msb_w;
    logic        toggle_w;
    logic        active_w;

    poll_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_i),
        .erase_i    (op_erase_i),
        .load_msb_i (load_byte_i[POLL_BIT]),
        .state_o    (state_w),
        .inv_msb_o  (inv_msb_w)
    );

    assign active_w = (state_w != ST_IDLE);

    poll_toggle toggle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active_w),
        .strobe_i (rd_strobe_i),
        .toggle_o (toggle_w)
    );

    poll_mux #(.DATA_W(DATA_W)) mux_i (
        .state_i   (state_w),
        .inv_msb_i (inv_msb_w),
        .toggle_i  (toggle_w),
        .array_i   (array_data_i),
        .data_o    (rd_data_o)
    );

    // marks that the previous edge was out of reset, for $past-based checks
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(busy_i) |-> rd_data_o == array_data_i);

    // R8
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(busy_i) |-> rd_data_o[TOG_BIT-1:0] == '0);

    // R5
    erase_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_w == ST_ERASE_BUSY |-> rd_data_o[POLL_BIT] == 1'b0);

    // R6
    toggle_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_w |-> rd_data_o[TOG_BIT] == toggle_w);

endmodule

// File: tb/poll_status_mux_tb.sv
module poll_status_mux_tb_top;

    localparam int DATA_W = 8;
    localparam int NVEC   = 20;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              busy_i;
    logic              op_erase_i;
    logic [DATA_W-1:0] load_byte_i;
    logic              rd_strobe_i;
    logic [DATA_W-1:0] array_data_i;
    logic [DATA_W-1:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    poll_status_mux #(.DATA_W(DATA_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .op_erase_i   (op_erase_i),
        .load_byte_i  (load_byte_i),
        .rd_strobe_i  (rd_strobe_i),
        .array_data_i (array_data_i),
        .rd_data_o    (rd_data_o)
    );

    // {busy, erase, strobe, load[7:0], array[7:0], expected[7:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 8'h3C}, // R2 idle
        {1'b1, 1'b0, 1'b0, 8'h85, 8'h11, 8'h00}, // R4 start_prog, msb 1 -> 0
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h22, 8'h40}, // R6 flip, R9 load change ignored
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h33, 8'h40}, // R6 held strobe, no flip
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h44, 8'h40}, // R8
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h55, 8'h00}, // R6 flip back
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h5A, 8'h5A}, // R10 finish
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 8'hA5}, // R7 idle strobe
        {1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 8'h00}, // R5 start_erase
        {1'b1, 1'b0, 1'b1, 8'hFF, 8'hFF, 8'h40}, // R9 erase flag drop ignored, R6
        {1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h40}, // R5
        {1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'h00}, // R6
        {1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, 8'hC3}, // R10
        {1'b1, 1'b0, 1'b1, 8'h7F, 8'h00, 8'h80}, // R7 entry-edge strobe, R4 msb 0 -> 1
        {1'b1, 1'b0, 1'b1, 8'h80, 8'h00, 8'h80}, // R9
        {1'b1, 1'b0, 1'b0, 8'h80, 8'h00, 8'h80}, // R4
        {1'b1, 1'b0, 1'b1, 8'h80, 8'h00, 8'hC0}, // R6
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h81, 8'h81}, // R10
        {1'b1, 1'b1, 1'b0, 8'h00, 8'h99, 8'h40}, // R10 toggle held into erase
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h7E, 8'h7E}  // R2
    };

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic b, input logic e, input logic s,
                         input logic [7:0] ld, input logic [7:0] arr);
        @(negedge clk);
        busy_i       = b;
        op_erase_i   = e;
        rd_strobe_i  = s;
        load_byte_i  = ld;
        array_data_i = arr;
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        busy_i       = 1'b1;
        op_erase_i   = 1'b0;
        load_byte_i  = 8'h80;
        rd_strobe_i  = 1'b1;
        array_data_i = 8'h96;
        settle();
        settle();
        check("R1 reset pass-through", rd_data_o, 8'h96);

        drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        rst_n = 1'b1;
        settle();

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
            settle();
            check($sformatf("R2-R10 vector %0d", i), rd_data_o, VEC[i][7:0]);
        end

        // R3: status only after the entry edge (toggle is 1 here)
        drive(1'b1, 1'b0, 1'b0, 8'h80, 8'h12);
        #1;
        check("R3 before entry edge", rd_data_o, 8'h12);
        settle();
        check("R3 after start_prog", rd_data_o, 8'h40);
        drive(1'b1, 1'b0, 1'b1, 8'h80, 8'h34);
        settle();
        check("R6 flip in prog", rd_data_o, 8'h00);

        // R1: reset mid-operation is asynchronous and clears the toggle
        drive(1'b1, 1'b0, 1'b0, 8'h80, 8'h6B);
        rst_n = 1'b0;
        #1;
        check("R1 async reset mid-busy", rd_data_o, 8'h6B);
        drive(1'b1, 1'b1, 1'b0, 8'h00, 8'h6B);
        rst_n = 1'b1;
        settle();
        check("R1 toggle cleared, R5 erase", rd_data_o, 8'h00);
        drive(1'b1, 1'b1, 1'b1, 8'h00, 8'hE7);
        settle();
        check("R6 first read after reset", rd_data_o, 8'h40);
        drive(1'b0, 1'b1, 1'b0, 8'h00, 8'hE7);
        settle();
        check("R10 finish from erase", rd_data_o, 8'hE7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule